// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This block lets on-chip logic drive an external three-wire serial EEPROM that holds 64 words of 16 bits. A client hands over one command at a time: an operation code, a word address and, for the programming commands, a data word. The controller builds the serial frame and drives chip select, serial clock and serial data out to the memory. On reads it gathers the returned word. On the programming commands it watches the memory's busy/ready line until the operation has finished. It then returns a response that carries the read word and an error flag.

The serial clock comes from the system clock. Each phase lasts `DIV_HALF` system cycles, so the default of 63 cycles at 125 MHz gives phases of 504 ns. `DIV_HALF` must be at least 3 so that the two-stage synchronizer on the memory's data line settles within one phase.

The command side is a valid/ready pair. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low from that cycle until the response has been taken, so at most one command is in flight. A response that is not taken holds its contents unchanged. The client may keep `rsp_ready` low for as long as it likes, and nothing on the serial side moves while it does.

Top module: `mw_eeprom_host`

## Requirements
- R1: Every frame sends a 1 start bit first, then two opcode bits, then the six address bits from most significant down, one bit per serial clock. `ee_di` changes only while `ee_sk` is low, and `ee_sk` is low whenever `ee_cs` is low.
- R2: `req_op` codes select the commands and their opcode bits on the wire:
  - 0 is read (10).
  - 1 is write (01).
  - 2 is erase (11).
  - 3 is enable (00 with address 110000).
  - 4 is disable (00 with address 000000).
  - 5 is erase-all (00 with address 100000).
  - 6 is write-all (00 with address 010000).
  For codes 3 to 6, `req_addr` is ignored.
- R3: Read, write and write-all frames last 25 serial clocks; erase, enable, disable and erase-all frames last 9. Write and write-all send the 16 data bits after the address, most significant bit first. A read holds `ee_di` low during its 16 data clocks.
- R4: On a read, `ee_do` is sampled at rising clock edges 10 to 25, giving bits 15 down to 0, and that word is returned on `rsp_rdata`. Other commands return 0.
- R5: Each serial clock phase lasts exactly `DIV_HALF` system cycles. `ee_cs` rises `DIV_HALF` cycles before the first rising clock edge. Every rise of `ee_cs` follows at least `DIV_HALF` cycles with `ee_cs` low.
- R6: After write, erase, erase-all or write-all, the controller does the following:
  - It holds `ee_cs` low for one phase.
  - It raises `ee_cs` again and waits one phase.
  - It then watches `ee_do` each cycle and responds with `rsp_err`=0 once `ee_do` reads high.
- R7: If `ee_do` is still low after `TIMEOUT_CYC` samples, the controller drops `ee_cs` and responds with `rsp_err`=1. The response appears `DIV_HALF`+`TIMEOUT_CYC` cycles after `ee_cs` rose for polling.
- R8: Read, enable and disable do not poll. The response follows the frame, with `ee_cs` low and only one chip-select pulse for the command.
- R9: `req_ready` is high only when idle with no response pending. While `rsp_valid` waits for `rsp_ready`, `rsp_rdata` and `rsp_err` hold and no request is accepted.
- R10: Code 7 is accepted and answered with `rsp_err`=1 without any chip-select activity.
- R11: After reset, `ee_cs`, `ee_sk`, `ee_di` and `rsp_valid` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Command offered |
| req_ready | output | 1 | Controller idle, command taken this cycle if valid |
| req_op | input | 3 | Command code (R2) |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Data for write and write-all |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Client takes the response |
| rsp_rdata | output | DATA_W | Word returned by a read |
| rsp_err | output | 1 | Poll timeout or invalid code |
| ee_cs | output | 1 | Chip select to the memory |
| ee_sk | output | 1 | Serial clock to the memory |
| ee_di | output | 1 | Serial data to the memory |
| ee_do | input | 1 | Serial data and busy/ready from the memory |

## Verification
The bench goes after the following corner cases:
- **Bit boundary in reads.** A design that started reading one clock early or late would return the word shifted by one bit.
- **Selector bits of the special commands.** A design that passed the client's address through would set the wrong mode on the memory.
- **Polling.** The bench makes the memory answer busy for several cycles, for zero cycles, and forever. A controller that skipped the settling phase would take the pulled-up idle level for ready. One with a wrong timeout count would report the error at the wrong cycle.
- **Response stall.** The response is held back while a new request is waiting. A design that dropped its response, or accepted the new request, would show it at once.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;

  typedef enum logic [2:0] {
    OP_READ      = 3'd0,
    OP_WRITE     = 3'd1,
    OP_ERASE     = 3'd2,
    OP_WREN      = 3'd3,
    OP_WRDIS     = 3'd4,
    OP_ERASE_ALL = 3'd5,
    OP_WRITE_ALL = 3'd6,
    OP_BAD       = 3'd7
  } mw_op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LEAD,
    S_SETUP,
    S_SHIFT,
    S_GAP,
    S_POLL,
    S_RESP
  } mw_state_e;

endpackage

// File: rtl/mw_half_timer.sv
module mw_half_timer #(
  parameter int DIV_HALF = 63
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = $clog2(DIV_HALF + 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(DIV_HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || tick)  cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/mw_do_sync.sv
module mw_do_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '1;
        else        pipe <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = pipe[STAGES-1];

endmodule

// File: rtl/mw_cmd_encode.sv
module mw_cmd_encode
  import mw_eeprom_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 16,
  parameter int CMD_W   = 3 + ADDR_W,
  parameter int FRAME_W = CMD_W + DATA_W,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  mw_op_e              op,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [FRAME_W-1:0]  frame,
  output logic [CNT_W-1:0]    nclk,
  output logic                poll,
  output logic                is_read,
  output logic                bad
);
  localparam int LOW_W = ADDR_W - 2;

  logic [1:0]        code;
  logic [ADDR_W-1:0] a;
  logic [DATA_W-1:0] d;
  logic              lng;

  always_comb begin
    code    = 2'b00;
    a       = addr;
    d       = '0;
    lng     = 1'b0;
    poll    = 1'b0;
    is_read = 1'b0;
    bad     = 1'b0;
    case (op)
      OP_READ:      begin code = 2'b10; lng = 1'b1; is_read = 1'b1; end
      OP_WRITE:     begin code = 2'b01; d = wdata; lng = 1'b1; poll = 1'b1; end
      OP_ERASE:     begin code = 2'b11; poll = 1'b1; end
      OP_WREN:      a = {2'b11, {LOW_W{1'b0}}};
      OP_WRDIS:     a = '0;
      OP_ERASE_ALL: begin a = {2'b10, {LOW_W{1'b0}}}; poll = 1'b1; end
      OP_WRITE_ALL: begin
        a = {2'b01, {LOW_W{1'b0}}}; d = wdata; lng = 1'b1; poll = 1'b1;
      end
      default:      bad = 1'b1;
    endcase
    frame = {1'b1, code, a, d};
    nclk  = lng ? CNT_W'(FRAME_W) : CNT_W'(CMD_W);
  end

endmodule

// File: rtl/mw_eeprom_host.sv
module mw_eeprom_host
  import mw_eeprom_pkg::*;
#(
  parameter int DIV_HALF    = 63,
  parameter int TIMEOUT_CYC = 1875000,
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              ee_cs,
  output logic              ee_sk,
  output logic              ee_di,
  input  logic              ee_do
);
  localparam int CMD_W   = 3 + ADDR_W;
  localparam int FRAME_W = CMD_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam int TMO_W   = $clog2(TIMEOUT_CYC + 1);
  localparam int PH_W    = $clog2(DIV_HALF + 1);

  mw_state_e          state;
  logic [FRAME_W-1:0] sreg;
  logic [CNT_W-1:0]   len_q, bitn;
  logic               poll_q, rd_q, settled;
  logic [TMO_W-1:0]   tmo;
  logic [DATA_W-1:0]  rdata_q;
  logic               err_q, cs_q, sck_q, di_q;

  logic [FRAME_W-1:0] enc_frame;
  logic [CNT_W-1:0]   enc_len;
  logic               enc_poll, enc_read, enc_bad;
  logic               tick, run, do_s;

  mw_cmd_encode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_W(CMD_W),
    .FRAME_W(FRAME_W), .CNT_W(CNT_W)
  ) u_enc (
    .op(mw_op_e'(req_op)), .addr(req_addr), .wdata(req_wdata),
    .frame(enc_frame), .nclk(enc_len), .poll(enc_poll),
    .is_read(enc_read), .bad(enc_bad)
  );

  assign run = (state == S_LEAD) || (state == S_SETUP) || (state == S_SHIFT) ||
               (state == S_GAP) || ((state == S_POLL) && !settled);

  mw_half_timer #(.DIV_HALF(DIV_HALF)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
  );

  mw_do_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(ee_do), .dout(do_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      sreg    <= '0;
      len_q   <= '0;
      bitn    <= '0;
      poll_q  <= 1'b0;
      rd_q    <= 1'b0;
      settled <= 1'b0;
      tmo     <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
      cs_q    <= 1'b0;
      sck_q   <= 1'b0;
      di_q    <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          rdata_q <= '0;
          err_q   <= 1'b0;
          if (enc_bad) begin
            err_q <= 1'b1;
            state <= S_RESP;
          end else begin
            sreg   <= enc_frame;
            len_q  <= enc_len;
            poll_q <= enc_poll;
            rd_q   <= enc_read;
            bitn   <= '0;
            state  <= S_LEAD;
          end
        end
        S_LEAD: if (tick) begin
          cs_q  <= 1'b1;
          di_q  <= sreg[FRAME_W-1];
          state <= S_SETUP;
        end
        S_SETUP: if (tick) begin
          sck_q <= 1'b1;
          bitn  <= CNT_W'(1);
          state <= S_SHIFT;
        end
        S_SHIFT: if (tick) begin
          if (sck_q) begin
            sck_q <= 1'b0;
            if (bitn == len_q) begin
              cs_q  <= 1'b0;
              di_q  <= 1'b0;
              state <= poll_q ? S_GAP : S_RESP;
            end else begin
              sreg <= {sreg[FRAME_W-2:0], 1'b0};
              di_q <= sreg[FRAME_W-2];
            end
          end else begin
            sck_q <= 1'b1;
            bitn  <= bitn + 1'b1;
            if (rd_q && (bitn >= CNT_W'(CMD_W)))
              rdata_q <= {rdata_q[DATA_W-2:0], do_s};
          end
        end
        S_GAP: if (tick) begin
          cs_q    <= 1'b1;
          settled <= 1'b0;
          tmo     <= '0;
          state   <= S_POLL;
        end
        S_POLL: begin
          if (!settled) begin
            if (tick) settled <= 1'b1;
          end else if (do_s) begin
            cs_q  <= 1'b0;
            state <= S_RESP;
          end else if (tmo == TMO_W'(TIMEOUT_CYC - 1)) begin
            cs_q  <= 1'b0;
            err_q <= 1'b1;
            state <= S_RESP;
          end else begin
            tmo <= tmo + 1'b1;
          end
        end
        S_RESP: if (rsp_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (state == S_IDLE);
  assign rsp_valid = (state == S_RESP);
  assign rsp_rdata = rdata_q;
  assign rsp_err   = err_q;
  assign ee_cs     = cs_q;
  assign ee_sk     = sck_q;
  assign ee_di     = di_q;

  // Phase-length observers used only by the properties below
  logic            sck_d;
  logic [PH_W-1:0] ph_len, cs_low_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d      <= 1'b0;
      ph_len     <= PH_W'(DIV_HALF);
      cs_low_len <= PH_W'(DIV_HALF);
    end else begin
      sck_d <= sck_q;
      if (sck_q != sck_d)                ph_len <= PH_W'(1);
      else if (ph_len != PH_W'(DIV_HALF)) ph_len <= ph_len + 1'b1;
      if (cs_q)                              cs_low_len <= '0;
      else if (cs_low_len != PH_W'(DIV_HALF)) cs_low_len <= cs_low_len + 1'b1;
    end
  end

  p_sck_needs_cs_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_q |-> !sck_q);

  p_di_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_q && sck_d) |-> $stable(di_q));

  p_phase_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_q != sck_d) |-> (ph_len >= PH_W'(DIV_HALF)));

  p_cs_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_q) |-> (cs_low_len >= PH_W'(DIV_HALF)));

  p_one_inflight_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));

  p_resp_cs_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!ee_cs && !ee_sk));

endmodule

// File: tb/mw_eeprom_host_tb_top.sv
`timescale 1ns/1ps
module mw_eeprom_host_tb_top;
  localparam int DH  = 4;
  localparam int TMO = 600;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, rsp_ready = 1'b0;
  logic [2:0] req_op = '0;
  logic [5:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_err, ee_cs, ee_sk, ee_di, ee_do;
  logic [15:0] rsp_rdata;

  always #4 clk = ~clk;

  mw_eeprom_host #(.DIV_HALF(DH), .TIMEOUT_CYC(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
  );

  // ---------------- behavioural memory model ----------------
  int cyc = 0;
  always @(posedge clk) cyc = cyc + 1;

  int busy_len = 40;
  bit stuck = 1'b0;
  logic [15:0] mem [64];
  bit wen = 1'b0;
  int nb = 0, nframes = 0, last_nb = 0, busy_until = 0;
  logic [24:0] sh = '0, last_sh = '0;
  logic [8:0] cmd9 = '0;
  logic [15:0] do_drv = '1;
  bit rd_act = 1'b0, sk_prev = 1'b0, cs_prev = 1'b0;
  logic busy;
  assign busy  = stuck || (cyc < busy_until);
  assign ee_do = ee_cs ? (rd_act ? do_drv[0] : !busy) : 1'b1;

  always @(ee_sk or ee_cs) begin
    if (ee_cs && !cs_prev) begin nb = 0; rd_act = 1'b0; end
    if (ee_cs && ee_sk && !sk_prev) begin
      sh = {sh[23:0], ee_di};
      nb = nb + 1;
      if (nb == 9) cmd9 = sh[8:0];
    end else if (ee_cs && !ee_sk && sk_prev) begin
      if (cmd9[7:6] == 2'b10 && nb >= 9 && nb <= 24) begin
        do_drv = {15'd0, mem[cmd9[5:0]][24-nb]};
        rd_act = 1'b1;
      end
    end
    if (!ee_cs && cs_prev) begin
      if (nb > 0) begin
        nframes = nframes + 1;
        last_nb = nb;
        last_sh = sh;
        case (cmd9[7:6])
          2'b01: if (nb == 25) begin
            if (wen) mem[cmd9[5:0]] = sh[15:0];
            busy_until = cyc + busy_len;
          end
          2'b11: begin
            if (wen) mem[cmd9[5:0]] = 16'hFFFF;
            busy_until = cyc + busy_len;
          end
          2'b00: case (cmd9[5:4])
            2'b11: wen = 1'b1;
            2'b00: wen = 1'b0;
            2'b10: begin
              if (wen) for (int i = 0; i < 64; i++) mem[i] = 16'hFFFF;
              busy_until = cyc + busy_len;
            end
            default: if (nb == 25) begin
              if (wen) for (int i = 0; i < 64; i++) mem[i] = sh[15:0];
              busy_until = cyc + busy_len;
            end
          endcase
          default: ;
        endcase
      end
      nb = 0;
      rd_act = 1'b0;
    end
    sk_prev = ee_sk;
    cs_prev = ee_cs;
  end

  // ---------------- per-clock protocol reference ----------------
  int mon_chk = 0, mon_err = 0;
  int csrises = 0, last_rise_cyc = 0;
  int ph = 0, since_cs = 0, low_n = 1000;
  bit first = 1'b0, msk_p = 1'b0, mcs_p = 1'b0, mdi_p = 1'b0;

  task automatic mchk(input bit ok, input string rq, input int act, input int exp);
    mon_chk++;
    if (!ok) begin
      mon_err++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", rq, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (ee_cs && !mcs_p) begin
        mchk(low_n >= DH, "R5 cs low time", low_n, DH);
        csrises++;
        last_rise_cyc = cyc;
        since_cs = 0;
        first = 1'b1;
      end
      if (ee_sk != msk_p) begin
        if (ee_sk && first) begin
          mchk(since_cs == DH, "R5 cs-to-first-clock", since_cs, DH);
          first = 1'b0;
        end else begin
          mchk(ph == DH, "R5 clock phase", ph, DH);
        end
        ph = 0;
      end
      if (ee_sk && msk_p) mchk(ee_di == mdi_p, "R1 di moved while clock high", ee_di, mdi_p);
      if (!ee_cs) mchk(!ee_sk, "R1 clock without cs", ee_sk, 0);
      if (!ee_cs) low_n++; else low_n = 0;
      ph++;
      since_cs++;
    end
    msk_p = ee_sk;
    mcs_p = ee_cs;
    mdi_p = ee_di;
  end

  // ---------------- stimulus and result checks ----------------
  int nchk = 0, nerr = 0;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", rq, act, exp, $time);
    end
  endtask

  task automatic run(input logic [2:0] op, input logic [5:0] a, input logic [15:0] wd,
                     input bit chk_rd, input logic [15:0] exp_rd, input bit exp_err);
    logic [24:0] f;
    int n, f0, r0, t_rsp;
    bit poll;
    logic [15:0] rd;
    logic er;
    poll = 1'b0; n = 9; f = '0;
    case (op)
      3'd0: begin f = {3'b110, a, 16'h0}; n = 25; end
      3'd1: begin f = {3'b101, a, wd}; n = 25; poll = 1'b1; end
      3'd2: begin f = {3'b111, a, 16'h0}; poll = 1'b1; end
      3'd3: f = {3'b100, 6'b110000, 16'h0};
      3'd4: f = {3'b100, 6'b000000, 16'h0};
      3'd5: begin f = {3'b100, 6'b100000, 16'h0}; poll = 1'b1; end
      3'd6: begin f = {3'b100, 6'b010000, wd}; n = 25; poll = 1'b1; end
      default: n = 0;
    endcase
    f0 = nframes; r0 = csrises;
    @(negedge clk);
    req_op = op; req_addr = a; req_wdata = wd; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    rd = rsp_rdata; er = rsp_err; t_rsp = cyc;
    chk(er == exp_err, exp_err && op != 3'd7 ? "R7 error flag" : "R6 error flag", er, exp_err);
    if (chk_rd) chk(rd == exp_rd, "R4 read data", rd, exp_rd);
    if (op != 3'd0) chk(rd == 16'h0, "R4 non-read data", rd, 0);
    chk(!ee_cs && !ee_sk, "R8 pins idle at response", {ee_cs, ee_sk}, 0);
    // hold the response while a new request waits
    req_op = 3'd7; req_valid = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(rsp_valid && rsp_rdata == rd && rsp_err == er && !req_ready,
          "R9 response held", {rsp_valid, req_ready, rsp_err}, {1'b1, 1'b0, er});
    end
    req_valid = 1'b0; rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid && req_ready, "R9 release", {rsp_valid, req_ready}, 2'b01);
    if (op == 3'd7) begin
      chk(nframes == f0 && csrises == r0, "R10 no cs activity", csrises - r0, 0);
    end else begin
      chk(nframes == f0 + 1, "R3 one frame", nframes - f0, 1);
      chk(last_nb == n, "R3 clock count", last_nb, n);
      if (n == 25) chk(last_sh == f, "R2 frame bits", last_sh, f);
      else         chk(last_sh[8:0] == f[24:16], "R2 frame bits", last_sh[8:0], f[24:16]);
      if (poll) chk(csrises - r0 == 2, "R6 poll pulse", csrises - r0, 2);
      else      chk(csrises - r0 == 1, "R8 single pulse", csrises - r0, 1);
      if (poll && !exp_err) begin
        chk(t_rsp >= busy_until, "R6 waits for ready", t_rsp, busy_until);
        chk(t_rsp <= ((busy_until > last_rise_cyc + DH) ? busy_until : last_rise_cyc + DH) + 6,
            "R6 prompt finish", t_rsp, busy_until);
      end
      if (exp_err) chk(t_rsp - last_rise_cyc == DH + TMO, "R7 timeout cycle",
                       t_rsp - last_rise_cyc, DH + TMO);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!ee_cs && !ee_sk && !ee_di, "R11 pins in reset", {ee_cs, ee_sk, ee_di}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R11 handshake after reset", {rsp_valid, req_ready}, 2'b01);
    chk(!ee_cs && !ee_sk && !ee_di, "R11 pins after reset", {ee_cs, ee_sk, ee_di}, 0);

    run(3'd3, 6'h0F, 16'h0, 0, 0, 0);          // enable, address ignored (R2)
    busy_len = 60;
    run(3'd1, 6'd5, 16'hA5C3, 0, 0, 0);        // write (R3)
    run(3'd0, 6'd5, 16'hFFFF, 1, 16'hA5C3, 0); // read back (R4)
    run(3'd1, 6'd63, 16'h8001, 0, 0, 0);
    run(3'd0, 6'd63, 16'h0, 1, 16'h8001, 0);
    busy_len = 30;
    run(3'd2, 6'd5, 16'h0, 0, 0, 0);           // erase
    run(3'd0, 6'd5, 16'h0, 1, 16'hFFFF, 0);
    busy_len = 80;
    run(3'd6, 6'h2A, 16'h1234, 0, 0, 0);       // write-all
    run(3'd0, 6'd0, 16'h0, 1, 16'h1234, 0);
    run(3'd0, 6'd40, 16'h0, 1, 16'h1234, 0);
    busy_len = 0;
    run(3'd1, 6'd9, 16'h0F0F, 0, 0, 0);        // ready at first poll
    run(3'd0, 6'd9, 16'h0, 1, 16'h0F0F, 0);
    busy_len = 50;
    run(3'd5, 6'h3F, 16'h0, 0, 0, 0);          // erase-all
    run(3'd0, 6'd63, 16'h0, 1, 16'hFFFF, 0);
    run(3'd4, 6'h3F, 16'h0, 0, 0, 0);          // disable
    run(3'd1, 6'd7, 16'h5555, 0, 0, 0);
    run(3'd0, 6'd7, 16'h0, 1, 16'hFFFF, 0);
    run(3'd7, 6'd1, 16'h0, 0, 0, 1);           // invalid code (R10)
    stuck = 1'b1;
    run(3'd2, 6'd3, 16'h0, 0, 0, 1);           // busy forever (R7)
    stuck = 1'b0;
    busy_len = 10;
    run(3'd3, 6'h00, 16'h0, 0, 0, 0);
    run(3'd1, 6'd3, 16'hBEEF, 0, 0, 0);
    run(3'd0, 6'd3, 16'h0, 1, 16'hBEEF, 0);
    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", nchk + mon_chk, nerr + mon_err);
    $finish;
  end

  initial begin
    #(8 * 200000);
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", nchk + mon_chk + 1, nerr + mon_err + 1);
    $finish;
  end

endmodule